// File: doc/BRIEF.md
# Simultaneous Sampling Trigger Scheduler

This block paces a bank of four eight-channel sampling converters from a single conversion-start strobe. Every converter receives the same strobe, so the rising edge of that strobe is the one sampling instant for all thirty-two channels. The spacing between rising edges comes from a period value in system-clock cycles. The high time of the strobe is a separate value and has no effect on the rate.

After each start, the scheduler watches the four active-high busy lines as one combined condition. When the last busy line drops, it issues a one-cycle readout request to a downstream transfer engine. It then waits for that engine's done pulse before it accepts the next start. If the readout is still open when the next period boundary arrives, that start edge is dropped and a sticky overrun flag is raised. If the busy lines do not drop within a programmable number of cycles after a start, a sticky timeout flag is raised and the scheduler goes back to waiting for the next boundary. Taking the enable low stops the schedule and clears both flags.

Top module: `samp_trig_sched`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, conv_start_o, rd_req_o, overrun_o and timeout_o are all 0.
- R2: When enable_i is first seen high at a clock edge, conv_start_o rises in the cycle that follows that edge (the first boundary is immediate).
- R3: While no overrun occurs, consecutive rising edges of conv_start_o are exactly period_i clock cycles apart.
- R4: conv_start_o stays high for width_i cycles; a width_i value below 2 gives a 2-cycle pulse.
- R5: rd_req_o is a one-cycle pulse that rises one cycle after the cycle in which the last of the four busy lines is low (combined busy going from any-high to all-low while a conversion is pending), and never while any converter is still busy.
- R6: If rd_done_i is seen at an edge that comes before the next period boundary edge, no overrun is flagged and the next start is issued on schedule.
- R7: If the readout is still open at a period boundary edge (this includes rd_done_i arriving at that very edge), overrun_o is set, that start edge is skipped, and the next start comes one period later.
- R8: overrun_o and timeout_o stay set while enable_i is high. Dropping enable_i clears every output at the next clock edge.
- R9: If the combined busy does not fall within timeout_i cycles of the start, timeout_o rises timeout_i+1 cycles after the start rising edge, no readout request is issued, and the next start still comes on schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable_i | input | 1 | Runs the sampling schedule; low stops it and clears the flags |
| period_i | input | PERIOD_W (16) | Sample period in clock cycles (values below 2 act as 2) |
| width_i | input | WIDTH_W (8) | Start-strobe high time in clock cycles (minimum 2) |
| timeout_i | input | TMO_W (12) | Limit in cycles for the busy lines to drop after a start (0 acts as 1) |
| busy_i | input | NUM_CONV (4) | Active-high busy lines, one per converter |
| rd_done_i | input | 1 | Pulse from the readout engine when the transfer is complete |
| conv_start_o | output | 1 | Shared conversion-start strobe; its rising edge is the sampling instant |
| rd_req_o | output | 1 | One-cycle request to begin the readout |
| overrun_o | output | 1 | Sticky: a start edge was skipped because the readout was still open |
| timeout_o | output | 1 | Sticky: the busy lines did not drop in time |

## Verification
The hardest cases to reach from the ports are the exact edge between a late readout and an overrun, and a conversion that never ends. The bench models four converters with staggered busy lengths and a readout engine with a fixed latency. Table rows place rd_done_i one cycle before the period boundary edge in one run and exactly on it in the next, so the skipped edge is seen as a doubled gap between start edges. A directed run holds the converters silent so that the timeout path fires, and the bench then checks that the schedule keeps its period afterwards.

// File: rtl/sts_pkg.sv
package sts_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } seq_state_e;

  localparam int unsigned STS_MIN_WIDTH  = 2;
  localparam int unsigned STS_MIN_PERIOD = 2;

endpackage

// File: rtl/sts_rst_sync.sv
module sts_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/sts_period_timer.sv
module sts_period_timer #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                boundary_o
);

  import sts_pkg::*;

  localparam logic [PERIOD_W-1:0] MIN_P = PERIOD_W'(STS_MIN_PERIOD);

  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic [PERIOD_W-1:0] last_cnt;

  assign last_cnt   = (period_i < MIN_P) ? (MIN_P - 1'b1) : (period_i - 1'b1);
  assign boundary_o = en_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (cnt_q >= last_cnt) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R3: a boundary is never followed directly by another one
  a_r3_boundary_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_o |=> !boundary_o);

endmodule

// File: rtl/sts_busy_merge.sv
module sts_busy_merge #(
  parameter int unsigned NUM_CONV = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CONV-1:0] busy_i,
  output logic                fall_o
);

  logic any_busy;
  logic any_q;

  // The busy lines are combined bit by bit so that NUM_CONV can change
  logic [NUM_CONV:0] or_chain;
  assign or_chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_CONV; g++) begin : g_or
    assign or_chain[g+1] = or_chain[g] | busy_i[g];
  end
  assign any_busy = or_chain[NUM_CONV];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      any_q <= 1'b0;
    end else begin
      any_q <= any_busy;
    end
  end

  assign fall_o = any_q && !any_busy;

  // R5: the combined fall only reports when every converter is idle
  a_r5_fall_all_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (busy_i == '0));

endmodule

// File: rtl/sts_strobe_gen.sv
module sts_strobe_gen #(
  parameter int unsigned WIDTH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               fire_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               strobe_o
);

  import sts_pkg::*;

  localparam logic [WIDTH_W-1:0] MIN_W = WIDTH_W'(STS_MIN_WIDTH);

  logic               strobe_q, strobe_d;
  logic [WIDTH_W-1:0] left_q, left_d;
  logic [WIDTH_W-1:0] width_eff;

  assign width_eff = (width_i < MIN_W) ? MIN_W : width_i;

  always_comb begin
    strobe_d = strobe_q;
    left_d   = left_q;
    if (!en_i) begin
      strobe_d = 1'b0;
      left_d   = '0;
    end else if (fire_i) begin
      strobe_d = 1'b1;
      left_d   = width_eff - 1'b1;
    end else if (strobe_q) begin
      if (left_q == '0) begin
        strobe_d = 1'b0;
      end else begin
        left_d = left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      left_q   <= '0;
    end else begin
      strobe_q <= strobe_d;
      left_q   <= left_d;
    end
  end

  assign strobe_o = strobe_q;

  // R4: a strobe that ends on its own has been high for at least two cycles
  a_r4_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(strobe_o) && $past(en_i)) |-> $past(strobe_o, 2));

endmodule

// File: rtl/sts_seq.sv
module sts_seq #(
  parameter int unsigned TMO_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             boundary_i,
  input  logic             busy_fall_i,
  input  logic             rd_done_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             fire_o,
  output logic             rd_req_o,
  output logic             overrun_o,
  output logic             timeout_o
);

  import sts_pkg::*;

  seq_state_e       st_q, st_d;
  logic [TMO_W-1:0] tcnt_q, tcnt_d;
  logic [TMO_W-1:0] tmo_eff;
  logic             req_q, req_d;
  logic             ovr_q, ovr_d;
  logic             tmo_q, tmo_d;

  assign tmo_eff = (timeout_i == '0) ? TMO_W'(1) : timeout_i;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    req_d  = 1'b0;
    ovr_d  = ovr_q;
    tmo_d  = tmo_q;
    fire_o = 1'b0;
    if (!en_i) begin
      st_d   = ST_IDLE;
      tcnt_d = '0;
      ovr_d  = 1'b0;
      tmo_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (boundary_i) begin
            fire_o = 1'b1;
            st_d   = ST_CONV;
            tcnt_d = '0;
          end
        end
        ST_CONV: begin
          if (busy_fall_i) begin
            st_d  = ST_READ;
            req_d = 1'b1;
          end else if (tcnt_q >= tmo_eff) begin
            st_d  = ST_IDLE;
            tmo_d = 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        ST_READ: begin
          if (rd_done_i) begin
            st_d = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
      if (boundary_i && (st_q != ST_IDLE)) begin
        ovr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      req_q  <= 1'b0;
      ovr_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      req_q  <= req_d;
      ovr_q  <= ovr_d;
      tmo_q  <= tmo_d;
    end
  end

  assign rd_req_o  = req_q;
  assign overrun_o = ovr_q;
  assign timeout_o = tmo_q;

  // R5: the readout request lasts a single cycle
  a_r5_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  // R8: overrun holds while the schedule runs
  a_r8_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && en_i) |=> overrun_o);

  // R8: timeout holds while the schedule runs
  a_r8_tmo_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && en_i) |=> timeout_o);

  // R7: a boundary that finds the readout open raises overrun
  a_r7_ovr_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && en_i && (st_q == ST_READ)) |=> overrun_o);

endmodule

// File: rtl/samp_trig_sched.sv
module samp_trig_sched #(
  parameter int unsigned NUM_CONV = 4,
  parameter int unsigned PERIOD_W = 16,
  parameter int unsigned WIDTH_W  = 8,
  parameter int unsigned TMO_W    = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [WIDTH_W-1:0]  width_i,
  input  logic [TMO_W-1:0]    timeout_i,
  input  logic [NUM_CONV-1:0] busy_i,
  input  logic                rd_done_i,
  output logic                conv_start_o,
  output logic                rd_req_o,
  output logic                overrun_o,
  output logic                timeout_o
);

  logic rst_n_s;
  logic boundary;
  logic busy_fall;
  logic fire;

  sts_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  sts_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .en_i       (enable_i),
    .period_i   (period_i),
    .boundary_o (boundary)
  );

  sts_busy_merge #(.NUM_CONV(NUM_CONV)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .busy_i (busy_i),
    .fall_o (busy_fall)
  );

  sts_seq #(.TMO_W(TMO_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .en_i        (enable_i),
    .boundary_i  (boundary),
    .busy_fall_i (busy_fall),
    .rd_done_i   (rd_done_i),
    .timeout_i   (timeout_i),
    .fire_o      (fire),
    .rd_req_o    (rd_req_o),
    .overrun_o   (overrun_o),
    .timeout_o   (timeout_o)
  );

  sts_strobe_gen #(.WIDTH_W(WIDTH_W)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .en_i     (enable_i),
    .fire_i   (fire),
    .width_i  (width_i),
    .strobe_o (conv_start_o)
  );

  // R5: a readout request follows a cycle with every busy line low
  a_r5_req_after_idle: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    rd_req_o |-> $past(busy_i == '0));

  // R2: a start edge only appears while the schedule is enabled
  a_r2_start_enabled: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $rose(conv_start_o) |-> $past(enable_i));

  // R1: nothing is asserted while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_n_s |-> !(conv_start_o || rd_req_o || overrun_o || timeout_o));

endmodule

// File: tb/samp_trig_sched_tb_top.sv
module samp_trig_sched_tb_top;

  localparam int NCONV = 4;
  localparam int PW    = 16;
  localparam int WW    = 8;
  localparam int TW    = 12;

  typedef struct packed {
    int per;
    int wid;
    int bl;
    int rl;
    int ovr;
  } vec_t;

  // period, width, busy length, readout latency, overrun expected
  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{40, 3, 10, 24, 0},
    '{40, 3, 10, 25, 1},
    '{64, 1, 20,  8, 0},
    '{25, 5,  5,  4, 0},
    '{100, 12, 30, 30, 0}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             enable;
  logic [PW-1:0]    period;
  logic [WW-1:0]    width;
  logic [TW-1:0]    tmo;
  logic [NCONV-1:0] busy;
  logic             rd_done;
  logic             conv_start, rd_req, overrun, timeout;

  always #2.5 clk = ~clk;

  samp_trig_sched #(
    .NUM_CONV(NCONV), .PERIOD_W(PW), .WIDTH_W(WW), .TMO_W(TW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .period_i(period),
    .width_i(width), .timeout_i(tmo), .busy_i(busy), .rd_done_i(rd_done),
    .conv_start_o(conv_start), .rd_req_o(rd_req), .overrun_o(overrun),
    .timeout_o(timeout)
  );

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  // model settings and records
  int cyc = 0;
  bit clr_req = 0;
  bit dead = 0;
  int m_bl = 10, m_rl = 10;
  int n_rise, w_meas, last_fall, rdreq_cyc, rdreq_first, rdreq_all, to_cyc;
  int rise_cyc [4];
  int bcnt [NCONV];
  int rcnt;
  bit ractive, cs_prev;

  initial begin
    busy = '0;
    rd_done = 1'b0;
  end

  // converter and readout models, sampling away from the clock edge
  always @(posedge clk) begin
    bit rising, prev_any;
    #2;
    cyc++;
    if (clr_req) begin
      n_rise = 0; w_meas = 0; last_fall = -1; rdreq_cyc = -1;
      rdreq_first = 0; rdreq_all = 0; to_cyc = -1;
      busy = '0; rd_done = 1'b0; ractive = 0; rcnt = 0;
      for (int i = 0; i < NCONV; i++) bcnt[i] = 0;
      cs_prev = conv_start;
    end else begin
      rising = conv_start && !cs_prev;
      if (rising) begin
        if (n_rise < 4) rise_cyc[n_rise] = cyc;
        n_rise++;
      end
      if (conv_start && n_rise == 1) w_meas++;
      if (rd_req) begin
        rdreq_all++;
        if (n_rise == 1) rdreq_first++;
        if (rdreq_cyc < 0) rdreq_cyc = cyc;
      end
      if (timeout && to_cyc < 0) to_cyc = cyc;
      rd_done = 1'b0;
      if (ractive) begin
        rcnt--;
        if (rcnt == 0) begin
          rd_done = 1'b1;
          ractive = 0;
        end
      end
      if (rd_req) begin
        ractive = 1;
        rcnt = m_rl;
      end
      prev_any = |busy;
      for (int i = 0; i < NCONV; i++) begin
        if (busy[i]) begin
          bcnt[i]--;
          if (bcnt[i] == 0) busy[i] = 1'b0;
        end
      end
      if (rising && !dead) begin
        for (int i = 0; i < NCONV; i++) begin
          busy[i] = 1'b1;
          bcnt[i] = m_bl + i;
        end
      end
      if (prev_any && busy == '0 && n_rise == 1 && last_fall < 0) last_fall = cyc;
      cs_prev = conv_start;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  task automatic clear_model();
    clr_req = 1;
    tick();
    clr_req = 0;
  endtask

  task automatic wait_rises(input int n, input string req);
    int g = 0;
    while (n_rise < n && g < 3000) begin
      tick();
      g++;
    end
    chk({req, " start edges seen"}, (n_rise >= n) ? 1 : 0, 1);
  endtask

  initial begin
    rst_n  = 1'b0;
    enable = 1'b0;
    period = PW'(40);
    width  = WW'(3);
    tmo    = TW'(200);
    repeat (4) tick();
    // R1: quiet while reset is held
    chk("R1 reset outputs", {28'd0, conv_start, rd_req, overrun, timeout}, 0);
    rst_n = 1'b1;
    repeat (10) tick();
    chk("R1 idle after reset", {28'd0, conv_start, rd_req, overrun, timeout}, 0);

    // table-driven runs
    for (int v = 0; v < NVEC; v++) begin
      int e, weff, nr, gap;
      enable = 1'b0;
      tick();
      clear_model();
      dead   = 0;
      m_bl   = VECS[v].bl;
      m_rl   = VECS[v].rl;
      period = PW'(VECS[v].per);
      width  = WW'(VECS[v].wid);
      tmo    = TW'(200);
      tick();
      e = cyc;
      enable = 1'b1;
      nr = (VECS[v].ovr != 0) ? 3 : 2;
      wait_rises(nr, "R3");
      weff = (VECS[v].wid < 2) ? 2 : VECS[v].wid;
      gap  = (VECS[v].ovr != 0) ? 2 * VECS[v].per : VECS[v].per;
      chk("R2 first start edge", rise_cyc[0], e + 1);
      if (VECS[v].ovr != 0) begin
        chk("R7 gap after skipped edge", rise_cyc[1] - rise_cyc[0], gap);
        chk("R7 gap stays doubled", rise_cyc[2] - rise_cyc[1], gap);
        chk("R7 overrun flag", overrun, 1);
      end else begin
        chk("R3 start edge spacing", rise_cyc[1] - rise_cyc[0], gap);
        chk("R6 no overrun", overrun, 0);
      end
      chk("R4 strobe width", w_meas, weff);
      chk("R5 request after last busy", rdreq_cyc, last_fall + 1);
      chk("R5 request pulse length", rdreq_first, 1);
      chk("R9 no timeout in normal run", timeout, 0);
    end

    // R9: converters never report busy
    enable = 1'b0;
    tick();
    clear_model();
    dead   = 1;
    period = PW'(60);
    width  = WW'(3);
    tmo    = TW'(20);
    tick();
    enable = 1'b1;
    wait_rises(2, "R9");
    chk("R9 timeout edge", to_cyc, rise_cyc[0] + 21);
    chk("R9 no readout request", rdreq_all, 0);
    chk("R9 schedule kept", rise_cyc[1] - rise_cyc[0], 60);
    chk("R8 timeout sticky", timeout, 1);
    chk("R8 overrun still clear", overrun, 0);

    // R8: dropping enable clears all outputs next edge
    enable = 1'b0;
    tick();
    chk("R8 clear on disable", {28'd0, conv_start, rd_req, overrun, timeout}, 0);

    // R8: clear an overrun the same way
    clear_model();
    dead   = 0;
    m_bl   = 10;
    m_rl   = 25;
    period = PW'(40);
    tmo    = TW'(200);
    tick();
    enable = 1'b1;
    wait_rises(3, "R7");
    chk("R7 overrun raised again", overrun, 1);
    enable = 1'b0;
    tick();
    chk("R8 overrun cleared", {28'd0, conv_start, rd_req, overrun, timeout}, 0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

endmodule